// File: doc/BRIEF.md
# Serial ADC Control-Byte Interface

This block models the digital side of a four-channel, 10-bit serial analog-to-digital converter that sits as a peripheral behind a host SPI master. While chip-select is low, the block watches the serial clock and data input for a start bit. It then collects a control word that selects the input channel, the input mode and the power state to take once the conversion is over. When the word is complete it captures a sample from a plain input port, which stands in for the analog front end. After a fixed conversion time it raises a one-clock ready strobe and sends the 10-bit result, followed by two zero sub-bits, most significant bit first on the serial output.

The host serial lines are sampled by the block's system clock; each serial clock edge is detected as a level change between two system clocks. A software power request takes effect only when the conversion finishes. An active-low shutdown input stops everything at once and drops the ready flag. After shutdown is released, the ready flag returns only after a fixed wake-up interval, and the block then resumes its last software power state.

Top module: `serial_adc_ctrl`

## Requirements
- R1: After reset, `pwr_state` is 0 (full power-down), `ready` is 1, and `dout`, `dout_oe`, `sstrb`, `chan_pos`, `chan_neg` and `unipolar` are all 0.
- R2: With `cs_n` low, `ready` high and the serial machine idle, rising `sclk` edges with `din` low are ignored. The first rising edge with `din` high is the start bit, and `pwr_state` reads 3 (full power) on the next clock.
- R3: The control word is sent MSB first, one bit per rising `sclk` edge: start, SEL2, SEL1, SEL0, UNI/BIP, SGL/DIF, PD1, PD0. When the conversion completes, `pwr_state` becomes {PD1,PD0}: 0 full power-down, 1 fast power-down, 2 reduced power, 3 stay powered.
- R4: The sample port is captured on the 8th rising edge of the word. `CONV_CYCLES` clocks after that edge, `sstrb` is high for exactly one clock.
- R5: In the clock where `sstrb` is high, `dout` shows B9. Each later falling `sclk` edge moves `dout` to the next bit, through B0 and then two zero sub-bits. The twelfth falling edge returns `dout` to 0 and the machine to idle.
- R6: A power-down code in the word takes effect only at the completion of the conversion; until then `pwr_state` stays 3.
- R7: `shdn_n` low makes `pwr_state` read 4 and `ready` read 0 on the next clock. It abandons any conversion, with no `sstrb` and `dout` at 0.
- R8: After `shdn_n` rises, `ready` returns to 1 after `WAKE_CYCLES` clocks (150 clocks, 1.5 us at 100 MHz, within the 2 us limit). Serial input is ignored until then. `pwr_state` then returns to the last software state.
- R9: At the end of a word, `chan_pos` becomes one-hot at index {SEL1,SEL0} if SEL2 is 0 and all zero if SEL2 is 1. `chan_neg` is one-hot at index {SEL1,~SEL0} when SGL/DIF is 0 (differential) and zero otherwise. `unipolar` copies UNI/BIP.
- R10: `cs_n` high returns the serial machine to idle and abandons any frame. `dout_oe` equals the inverse of `cs_n`, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data in |
| shdn_n | input | 1 | Active-low hardware shutdown |
| sample | input | RES_W | Stubbed conversion value |
| dout | output | 1 | Serial result data out |
| dout_oe | output | 1 | Output enable for dout (tri-state model) |
| sstrb | output | 1 | One-clock result-ready strobe |
| pwr_state | output | 3 | 0 full off, 1 fast off, 2 reduced, 3 on, 4 hardware off |
| ready | output | 1 | High when the block accepts serial traffic |
| chan_pos | output | N_CH | One-hot positive input selected |
| chan_neg | output | N_CH | One-hot negative input in differential mode |
| unipolar | output | 1 | Decoded UNI/BIP mode bit |

## Verification
A cycle-level behavioural model in the bench, built on a bit queue and integers, is compared with every output on every clock. Control words cover all four power codes, single-ended and differential channels, and an out-of-range SEL2. These patterns separate the field order, the channel decode and the timing of the power change. Leading zero bits before the start bit test start-bit hunting. Sample values such as 0x2A5, 0x155, 0x3FF and 0 expose shift-order and bit-drop errors. Chip-select and shutdown are dropped mid-conversion to separate a clean abort from a completed one. Traffic sent during the wake interval checks that it is ignored.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [2:0] {
    PW_FULL_OFF = 3'd0,
    PW_FAST_OFF = 3'd1,
    PW_REDUCED  = 3'd2,
    PW_ON       = 3'd3,
    PW_HW_OFF   = 3'd4
  } pwr_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ACQ,
    ST_CONV,
    ST_SHIFT
  } seq_e;

  // control word body following the start bit, MSB first on the wire
  typedef struct packed {
    logic [2:0] sel;
    logic       unipolar;
    logic       single;
    logic [1:0] pd;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t) + 1;

endpackage

// File: rtl/sadc_sclk_edge.sv
module sadc_sclk_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sclk;
  end

  assign rise = sclk & ~prev_q;
  assign fall = ~sclk & prev_q;
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int SUB_W       = 2,
  parameter int ACQ_FIRST   = 6,
  parameter int CONV_CYCLES = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             rise,
  input  logic             fall,
  input  logic             din,
  input  logic [RES_W-1:0] sample,
  output logic             dout,
  output logic             sstrb,
  output logic             start_evt,
  output logic             conv_done,
  output logic             word_done,
  output ctrl_t            word,
  output logic [1:0]       pd_req
);
  localparam int FRAME_W = RES_W + SUB_W;
  localparam int BODY_W  = CTRL_W - 1;
  localparam int BIT_CW  = $clog2(CTRL_W + 1);
  localparam int CONV_CW = $clog2(CONV_CYCLES + 1);
  localparam int OUT_CW  = $clog2(FRAME_W + 1);
  localparam logic [BIT_CW-1:0]  BITS_TO_ACQ = BIT_CW'(ACQ_FIRST - 2);
  localparam logic [BIT_CW-1:0]  BITS_LAST   = BIT_CW'(CTRL_W - 1);
  localparam logic [CONV_CW-1:0] CONV_LAST   = CONV_CW'(CONV_CYCLES - 1);
  localparam logic [OUT_CW-1:0]  OUT_LAST    = OUT_CW'(FRAME_W - 1);

  seq_e                state_q;
  logic [BIT_CW-1:0]   bits_q;
  logic [BODY_W-2:0]   body_q;
  logic [CONV_CW-1:0]  conv_q;
  logic [OUT_CW-1:0]   obits_q;
  logic [RES_W-1:0]    held_q;
  logic [FRAME_W-1:0]  shreg_q;
  logic [1:0]          pd_q;
  logic                dout_q;
  logic                sstrb_q;

  assign start_evt = run && (state_q == ST_IDLE) && rise && din;
  assign word_done = run && (state_q == ST_ACQ) && rise && (bits_q == BITS_LAST);
  assign conv_done = run && (state_q == ST_CONV) && (conv_q == CONV_LAST);
  assign word      = ctrl_t'({body_q, din});
  assign pd_req    = pd_q;
  assign dout      = dout_q;
  assign sstrb     = sstrb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      body_q  <= '0;
      conv_q  <= '0;
      obits_q <= '0;
      held_q  <= '0;
      shreg_q <= '0;
      pd_q    <= 2'b00;
      dout_q  <= 1'b0;
      sstrb_q <= 1'b0;
    end else begin
      sstrb_q <= 1'b0;
      if (!run) begin
        state_q <= ST_IDLE;
        bits_q  <= '0;
        conv_q  <= '0;
        obits_q <= '0;
        dout_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (rise && din) begin
              state_q <= ST_CTRL;
              bits_q  <= BIT_CW'(1);
              body_q  <= '0;
            end
          end
          ST_CTRL: begin
            if (rise) begin
              body_q <= {body_q[BODY_W-3:0], din};
              bits_q <= bits_q + 1'b1;
              if (bits_q == BITS_TO_ACQ) state_q <= ST_ACQ;
            end
          end
          ST_ACQ: begin
            if (rise) begin
              if (bits_q == BITS_LAST) begin
                state_q <= ST_CONV;
                conv_q  <= '0;
                held_q  <= sample;
                pd_q    <= word.pd;
              end else begin
                body_q <= {body_q[BODY_W-3:0], din};
                bits_q <= bits_q + 1'b1;
              end
            end
          end
          ST_CONV: begin
            if (conv_q == CONV_LAST) begin
              state_q <= ST_SHIFT;
              sstrb_q <= 1'b1;
              shreg_q <= {held_q, {SUB_W{1'b0}}};
              dout_q  <= held_q[RES_W-1];
              obits_q <= '0;
            end else begin
              conv_q <= conv_q + 1'b1;
            end
          end
          ST_SHIFT: begin
            if (fall) begin
              if (obits_q == OUT_LAST) begin
                state_q <= ST_IDLE;
                dout_q  <= 1'b0;
              end else begin
                shreg_q <= shreg_q << 1;
                dout_q  <= shreg_q[FRAME_W-2];
                obits_q <= obits_q + 1'b1;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R4: the ready strobe never lasts two clocks
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    sstrb_q |=> !sstrb_q);

  // R10 / R7: a stopped frame produces no strobe and a quiet output
  a_r10_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!sstrb_q && !dout_q));

  // R5: result bits move only on falling serial clock edges
  a_r5_shift_on_fall: assert property (@(posedge clk) disable iff (rst)
    (run && state_q == ST_SHIFT && !fall) |=> $stable(dout_q));
endmodule

// File: rtl/sadc_chan_dec.sv
module sadc_chan_dec
  import sadc_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  ctrl_t           word,
  output logic [N_CH-1:0] chan_pos,
  output logic [N_CH-1:0] chan_neg,
  output logic            unipolar
);
  localparam int IDX_W = $clog2(N_CH);

  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic [N_CH-1:0]  pos_n, neg_n;
  logic [N_CH-1:0]  pos_q, neg_q;
  logic             uni_q;

  assign idx      = word.sel[IDX_W-1:0];
  assign in_range = (word.sel >> IDX_W) == '0;

  for (genvar g = 0; g < N_CH; g++) begin : g_dec
    assign pos_n[g] = in_range && (idx == IDX_W'(g));
    assign neg_n[g] = in_range && !word.single && ((idx ^ IDX_W'(1)) == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      neg_q <= '0;
      uni_q <= 1'b0;
    end else if (load) begin
      pos_q <= pos_n;
      neg_q <= neg_n;
      uni_q <= word.unipolar;
    end
  end

  assign chan_pos = pos_q;
  assign chan_neg = neg_q;
  assign unipolar = uni_q;

  // R9: at most one input on each side
  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pos_q) && $onehot0(neg_q));
endmodule

// File: rtl/sadc_pwr.sv
module sadc_pwr
  import sadc_pkg::*;
#(
  parameter int WAKE_CYCLES = 150
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       shdn_n,
  input  logic       start_evt,
  input  logic       conv_done,
  input  logic [1:0] pd_req,
  output pwr_e       pwr_state,
  output logic       ready
);
  localparam int WK_CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [WK_CW-1:0] WAKE_LAST = WK_CW'(WAKE_CYCLES - 1);

  pwr_e             pwr_q, sw_q;
  logic             waking_q, ready_q;
  logic [WK_CW-1:0] wake_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q    <= PW_FULL_OFF;
      sw_q     <= PW_FULL_OFF;
      waking_q <= 1'b0;
      ready_q  <= 1'b1;
      wake_q   <= '0;
    end else if (!shdn_n) begin
      pwr_q    <= PW_HW_OFF;
      waking_q <= 1'b1;
      ready_q  <= 1'b0;
      wake_q   <= '0;
    end else if (waking_q) begin
      if (wake_q == WAKE_LAST) begin
        waking_q <= 1'b0;
        ready_q  <= 1'b1;
        pwr_q    <= sw_q;
      end else begin
        wake_q <= wake_q + 1'b1;
      end
    end else if (start_evt) begin
      pwr_q <= PW_ON;
      sw_q  <= PW_ON;
    end else if (conv_done) begin
      pwr_q <= pwr_e'({1'b0, pd_req});
      sw_q  <= pwr_e'({1'b0, pd_req});
    end
  end

  assign pwr_state = pwr_q;
  assign ready     = ready_q;

  // R7: shutdown forces hardware power-down and drops ready
  a_r7_hw_off: assert property (@(posedge clk) disable iff (rst)
    !shdn_n |=> (pwr_q == PW_HW_OFF && !ready_q));

  // R8: ready only returns while shutdown is released
  a_r8_ready_return: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> $past(shdn_n));

  // R6: leaving full power in software needs a finished conversion
  a_r6_pd_after_conv: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr_q) == PW_ON && pwr_q != PW_ON && pwr_q != PW_HW_OFF) |-> $past(conv_done));
endmodule

// File: rtl/serial_adc_ctrl.sv
module serial_adc_ctrl
  import sadc_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int SUB_W       = 2,
  parameter int N_CH        = 4,
  parameter int ACQ_FIRST   = 6,
  parameter int CONV_CYCLES = 40,
  parameter int WAKE_CYCLES = 150
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic             shdn_n,
  input  logic [RES_W-1:0] sample,
  output logic             dout,
  output logic             dout_oe,
  output logic             sstrb,
  output logic [2:0]       pwr_state,
  output logic             ready,
  output logic [N_CH-1:0]  chan_pos,
  output logic [N_CH-1:0]  chan_neg,
  output logic             unipolar
);
  logic       rise, fall, run;
  logic       start_evt, conv_done, word_done;
  ctrl_t      word;
  logic [1:0] pd_req;
  pwr_e       pwr_s;
  logic       ready_s;
  logic       oe_q;

  assign run = ~cs_n & shdn_n & ready_s;

  sadc_sclk_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk),
    .rise (rise),
    .fall (fall)
  );

  sadc_seq #(
    .RES_W       (RES_W),
    .SUB_W       (SUB_W),
    .ACQ_FIRST   (ACQ_FIRST),
    .CONV_CYCLES (CONV_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .rise      (rise),
    .fall      (fall),
    .din       (din),
    .sample    (sample),
    .dout      (dout),
    .sstrb     (sstrb),
    .start_evt (start_evt),
    .conv_done (conv_done),
    .word_done (word_done),
    .word      (word),
    .pd_req    (pd_req)
  );

  sadc_chan_dec #(.N_CH(N_CH)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .load     (word_done),
    .word     (word),
    .chan_pos (chan_pos),
    .chan_neg (chan_neg),
    .unipolar (unipolar)
  );

  sadc_pwr #(.WAKE_CYCLES(WAKE_CYCLES)) u_pwr (
    .clk       (clk),
    .rst       (rst),
    .shdn_n    (shdn_n),
    .start_evt (start_evt),
    .conv_done (conv_done),
    .pd_req    (pd_req),
    .pwr_state (pwr_s),
    .ready     (ready_s)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= ~cs_n;
  end

  assign dout_oe   = oe_q;
  assign pwr_state = pwr_s;
  assign ready     = ready_s;

  // R10: output enable follows chip select one clock later
  a_r10_oe_follow: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !dout_oe);
endmodule

// File: tb/serial_adc_ctrl_tb.sv
module serial_adc_ctrl_tb;
  localparam int CONV = 40;
  localparam int WAKE = 150;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, shdn_n = 1'b1;
  logic [9:0] sample = '0;
  logic dout, dout_oe, sstrb, ready, unipolar;
  logic [2:0] pwr_state;
  logic [3:0] chan_pos, chan_neg;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_adc_ctrl #(.CONV_CYCLES(CONV), .WAKE_CYCLES(WAKE)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .shdn_n(shdn_n), .sample(sample), .dout(dout), .dout_oe(dout_oe),
    .sstrb(sstrb), .pwr_state(pwr_state), .ready(ready),
    .chan_pos(chan_pos), .chan_neg(chan_neg), .unipolar(unipolar)
  );

  // ---------------- behavioural reference model ----------------
  int m_prev, m_state, m_bits, m_word, m_cnt, m_held, m_pd;
  int m_dout, m_sstrb, m_pwr, m_sw, m_ready, m_waking, m_wait, m_oe;
  int m_pos, m_neg, m_uni;
  int outq[$];
  bit m_live = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_prev = 0; m_state = 0; m_bits = 0; m_word = 0; m_cnt = 0; m_held = 0; m_pd = 0;
      m_dout = 0; m_sstrb = 0; m_pwr = 0; m_sw = 0; m_ready = 1; m_waking = 0; m_wait = 0;
      m_oe = 0; m_pos = 0; m_neg = 0; m_uni = 0;
      outq.delete();
      m_live = 1;
    end else begin
      int r, f, go, st, dn, sel;
      r = (sclk && !m_prev) ? 1 : 0;
      f = (!sclk && m_prev) ? 1 : 0;
      m_prev = sclk;
      go = (!cs_n && shdn_n && m_ready) ? 1 : 0;
      st = (go && m_state == 0 && r && din) ? 1 : 0;
      dn = (go && m_state == 3 && m_cnt == CONV - 1) ? 1 : 0;
      m_oe = !cs_n;
      m_sstrb = 0;
      if (!go) begin
        m_state = 0; m_dout = 0; outq.delete();
      end else if (m_state == 0) begin
        if (st) begin m_state = 1; m_bits = 1; m_word = 1; end
      end else if (m_state == 1) begin
        if (r) begin
          m_word = m_word * 2 + din;
          m_bits++;
          if (m_bits == 8) begin
            m_state = 3; m_cnt = 0; m_held = sample; m_pd = m_word % 4;
            sel = (m_word / 16) % 8;
            m_uni = (m_word / 8) % 2;
            if (sel < 4) begin
              m_pos = 1 << sel;
              m_neg = ((m_word / 4) % 2) ? 0 : (1 << (sel ^ 1));
            end else begin
              m_pos = 0; m_neg = 0;
            end
          end
        end
      end else if (m_state == 3) begin
        if (m_cnt == CONV - 1) begin
          m_state = 4; m_sstrb = 1;
          for (int i = 9; i >= 0; i--) outq.push_back((m_held >> i) & 1);
          outq.push_back(0); outq.push_back(0);
          m_dout = outq.pop_front();
        end else m_cnt++;
      end else if (m_state == 4) begin
        if (f) begin
          if (outq.size() == 0) begin m_state = 0; m_dout = 0; end
          else m_dout = outq.pop_front();
        end
      end
      if (!shdn_n) begin
        m_waking = 1; m_wait = 0; m_ready = 0; m_pwr = 4;
      end else if (m_waking) begin
        if (m_wait == WAKE - 1) begin m_waking = 0; m_ready = 1; m_pwr = m_sw; end
        else m_wait++;
      end else if (st) begin
        m_pwr = 3; m_sw = 3;
      end else if (dn) begin
        m_pwr = m_pd; m_sw = m_pd;
      end
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_live && !done) begin
      cmp("R5 dout", int'(dout), m_dout);
      cmp("R4 sstrb", int'(sstrb), m_sstrb);
      cmp("R3/R6/R7 pwr_state", int'(pwr_state), m_pwr);
      cmp("R8 ready", int'(ready), m_ready);
      cmp("R9 chan_pos", int'(chan_pos), m_pos);
      cmp("R9 chan_neg", int'(chan_neg), m_neg);
      cmp("R9 unipolar", int'(unipolar), m_uni);
      cmp("R10 dout_oe", int'(dout_oe), m_oe);
    end
  end

  // ---------------- stimulus ----------------
  task automatic sclk_cycle(input logic d);
    din = d;
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] w, input int lead, input int total);
    for (int i = 0; i < lead; i++) sclk_cycle(1'b0);
    for (int i = 7; i >= 0; i--) sclk_cycle(w[i]);
    for (int i = lead + 8; i < total; i++) sclk_cycle(1'b0);
    sclk = 1'b0; din = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset values
    cmp("R1 pwr_state", int'(pwr_state), 0);
    cmp("R1 ready", int'(ready), 1);
    cmp("R1 sstrb", int'(sstrb), 0);
    cmp("R1 dout_oe", int'(dout_oe), 0);

    cs_n = 1'b0;
    sample = 10'h2A5;
    // R2: start bit then channel 0 single-ended, stay powered
    sclk_cycle(1'b0);
    sclk_cycle(1'b1);
    cmp("R2 start wakes", int'(pwr_state), 3);
    for (int i = 6; i >= 0; i--) sclk_cycle(logic'((8'b1_000_0_1_11 >> i) & 1));
    for (int i = 0; i < 21; i++) sclk_cycle(1'b0);
    sclk = 1'b0; repeat (HALF) @(negedge clk);
    cmp("R3 code 11 keeps on", int'(pwr_state), 3);

    // R6 / R9: channel 3 differential, fast power-down, leading zeros
    sample = 10'h155;
    frame(8'b1_011_0_0_01, 3, 32);
    cmp("R6 fast off after conv", int'(pwr_state), 1);
    cmp("R9 differential neg", int'(chan_neg), 4'b0100);

    // R9: SEL2 set gives no channel, full power-down
    sample = 10'h3FF;
    frame(8'b1_100_1_1_00, 0, 30);
    cmp("R9 out of range", int'(chan_pos), 0);
    cmp("R3 code 00", int'(pwr_state), 0);

    // R3: reduced power
    sample = 10'h000;
    frame(8'b1_010_1_1_10, 1, 30);
    cmp("R3 code 10", int'(pwr_state), 2);

    // R10: chip select abort during conversion
    sample = 10'h0F0;
    for (int i = 7; i >= 0; i--) sclk_cycle(logic'((8'b1_001_0_1_00 >> i) & 1));
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    cmp("R10 oe low", int'(dout_oe), 0);
    repeat (60) @(negedge clk);
    cmp("R10 abort keeps on", int'(pwr_state), 3);
    cs_n = 1'b0;
    frame(8'b1_001_0_1_01, 0, 30);

    // R7 / R8: shutdown during conversion, traffic during wake ignored
    sample = 10'h3C3;
    for (int i = 7; i >= 0; i--) sclk_cycle(logic'((8'b1_010_0_1_00 >> i) & 1));
    shdn_n = 1'b0;
    repeat (2) @(negedge clk);
    cmp("R7 hw off", int'(pwr_state), 4);
    cmp("R7 ready low", int'(ready), 0);
    repeat (20) @(negedge clk);
    shdn_n = 1'b1;
    for (int i = 7; i >= 0; i--) sclk_cycle(logic'((8'b1_011_0_0_00 >> i) & 1));
    cmp("R8 ignored while waking", int'(pwr_state), 4);
    repeat (WAKE) @(negedge clk);
    cmp("R8 ready back", int'(ready), 1);
    cmp("R8 last sw state", int'(pwr_state), 3);
    frame(8'b1_000_0_1_01, 2, 30);
    cmp("R3 code 01", int'(pwr_state), 1);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule